// File: doc/BRIEF.md
# Per-Core Interrupt Controller Register Bank

This block holds the software-visible configuration and status words of a per-core interrupt controller. Software reaches it through a single-port access interface. Each access is one aligned 32-bit read or write at a byte offset inside a 4 KB window. The decoder looks at the offset word by word, at 8-byte granularity, and ignores the three low address bits. Writes go through per-register masks and side effects. Read data comes back from a register one cycle after the read is accepted.

The block drives three signals to the neighbouring logic. The first is the current task-priority byte. The second is the software-enable bit taken from the spurious-vector word. The third is a one-cycle end-of-interrupt strobe. It also exposes three vector arrays as read-only status words: pending requests, in-service and trigger mode. Those arrays, the timer's live count and the error bits are supplied by the surrounding logic. Arbitration and the timer itself sit elsewhere.

Top module: `intc_regbank`

## Requirements
- R1: After reset the bank reads as follows: ID 0, task priority 0, destination format 0xFFFFFFFF, spurious vector 0x000000FF, every vector-table entry 0x00010000, divide 0, initial count 0 and error status 0. At the same time `tpr_o`, `sw_en_o`, `eoi_o`, `rvalid_o` and `rd_err_o` are all 0.
- R2: A write to ID (0x20) or task priority (0x80) stores only bits 7:0, and the rest read as 0. `tpr_o` shows the stored task-priority byte from the cycle after the write.
- R3: A write to logical destination (0xD0) keeps only bits 31:24. A write to destination format (0xE0) keeps bits 31:28 and always reads bits 27:0 as one.
- R4: Version (0x30) always reads the parameter `VERSION`. Current count (0x390) always reads `cur_count_i`. Writes to either have no effect.
- R5: The six vector-table entries sit at 0x320 + 0x10·k. In each entry, bits 12 and 14 cannot be written and keep their previous value. All other bits take the written value.
- R6: Error status (0x280) ORs in `esr_set_i` every cycle. A write while the internal flag is clear only sets the flag. A write while the flag is set clears the register and the flag. A read of 0x280 clears the flag.
- R7: A write to end-of-interrupt (0xB0) raises `eoi_o` for exactly the next cycle. It stores nothing, and 0xB0 reads 0.
- R8: A write to the spurious vector (0xF0) stores all 32 bits. `sw_en_o` equals bit 8 of the stored value.
- R9: A write to divide (0x3E0) keeps only bits 3, 1 and 0 (mask 0xB). Initial count (0x380) stores all 32 bits.
- R10: Array word k (k = 0..15) of in-service sits at 0x100 + 8k, of trigger mode at 0x180 + 8k, and of request at 0x200 + 8k. Bits 15:0 of word k hold vectors 16k..16k+15, with the lowest vector in bit 0. Bits 31:16 read 0, and writes to these words have no effect.
- R11: `rdata_o` and `rvalid_o` are valid in the cycle after the read is accepted. `rvalid_o` is high for that one cycle. Address bits 2:0 are ignored, so 0x24 reads the same as 0x20.
- R12: A read of any offset not listed above returns 0 and raises `rd_err_o` together with `rvalid_o`. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, accepted every cycle it is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| irr_i | input | 256 | Pending-request vector bits |
| isr_i | input | 256 | In-service vector bits |
| tmr_i | input | 256 | Trigger-mode vector bits |
| cur_count_i | input | 32 | Live timer count |
| esr_set_i | input | 8 | Error bits to set in error status |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| rd_err_o | output | 1 | Read hit a reserved offset |
| tpr_o | output | 8 | Task-priority byte |
| sw_en_o | output | 1 | Software enable |
| eoi_o | output | 1 | End-of-interrupt strobe |

## Verification
Most internal state here shows up only on a readback, one cycle after the read is accepted. The exceptions are the task-priority byte, the software-enable bit and the end-of-interrupt strobe. Those three appear at the ports in the cycle right after the write that moves them.

The error-status flag is the one piece of state that no read reveals. A stuck or mistimed flag shows only as a clear arriving one write too early or too late. For that reason the write, read and clear sequences are run with the register read back after each step.

Masking errors show as wrong bits on the very next readback. Decode errors show as data from the wrong word or as a missing or spurious `rd_err_o`.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [3:0] {
    SEL_NONE, SEL_ID, SEL_VER, SEL_TPR, SEL_EOI, SEL_LDR, SEL_DFR, SEL_SVR,
    SEL_ISR, SEL_TMR, SEL_IRR, SEL_ESR, SEL_LVT, SEL_ICNT, SEL_CCNT, SEL_DIV
  } reg_sel_e;

  // word index = byte offset / 8
  localparam int W_ID   = 'h020 / 8;
  localparam int W_VER  = 'h030 / 8;
  localparam int W_TPR  = 'h080 / 8;
  localparam int W_EOI  = 'h0B0 / 8;
  localparam int W_LDR  = 'h0D0 / 8;
  localparam int W_DFR  = 'h0E0 / 8;
  localparam int W_SVR  = 'h0F0 / 8;
  localparam int W_ISR  = 'h100 / 8;
  localparam int W_TMR  = 'h180 / 8;
  localparam int W_IRR  = 'h200 / 8;
  localparam int W_ESR  = 'h280 / 8;
  localparam int W_LVT  = 'h320 / 8;
  localparam int W_ICNT = 'h380 / 8;
  localparam int W_CCNT = 'h390 / 8;
  localparam int W_DIV  = 'h3E0 / 8;

  localparam logic [31:0] LVT_RO_MASK = 32'h0000_5000;
  localparam logic [31:0] LVT_RST     = 32'h0001_0000;
endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int ARR_WORDS = 16,
  parameter int NUM_LVT   = 6,
  localparam int IDX_W    = $clog2(ARR_WORDS),
  localparam int LVT_W    = $clog2(NUM_LVT)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [IDX_W-1:0]  arr_idx_o,
  output logic [LVT_W-1:0]  lvt_idx_o
);
  logic unused_low;
  assign unused_low = ^addr_i[2:0];

  int unsigned wi;

  always_comb begin
    wi        = 32'(addr_i[ADDR_W-1:3]);
    sel_o     = SEL_NONE;
    arr_idx_o = '0;
    lvt_idx_o = '0;
    if (wi == W_ID)        sel_o = SEL_ID;
    else if (wi == W_VER)  sel_o = SEL_VER;
    else if (wi == W_TPR)  sel_o = SEL_TPR;
    else if (wi == W_EOI)  sel_o = SEL_EOI;
    else if (wi == W_LDR)  sel_o = SEL_LDR;
    else if (wi == W_DFR)  sel_o = SEL_DFR;
    else if (wi == W_SVR)  sel_o = SEL_SVR;
    else if (wi == W_ESR)  sel_o = SEL_ESR;
    else if (wi == W_ICNT) sel_o = SEL_ICNT;
    else if (wi == W_CCNT) sel_o = SEL_CCNT;
    else if (wi == W_DIV)  sel_o = SEL_DIV;
    else if (wi >= W_ISR && wi < W_ISR + ARR_WORDS) begin
      sel_o = SEL_ISR; arr_idx_o = IDX_W'(wi - W_ISR);
    end else if (wi >= W_TMR && wi < W_TMR + ARR_WORDS) begin
      sel_o = SEL_TMR; arr_idx_o = IDX_W'(wi - W_TMR);
    end else if (wi >= W_IRR && wi < W_IRR + ARR_WORDS) begin
      sel_o = SEL_IRR; arr_idx_o = IDX_W'(wi - W_IRR);
    end else if (wi >= W_LVT && wi < W_LVT + 2 * NUM_LVT && !wi[0]) begin
      // vector-table entries at a 16-byte stride
      sel_o = SEL_LVT; lvt_idx_o = LVT_W'((wi - W_LVT) >> 1);
    end
  end
endmodule

// File: rtl/intc_wregs.sv
module intc_wregs
  import intc_pkg::*;
#(
  parameter int NUM_LVT = 6,
  parameter int ESR_W   = 8,
  localparam int LVT_W  = $clog2(NUM_LVT)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  reg_sel_e                 sel_i,
  input  logic [LVT_W-1:0]         lvt_idx_i,
  input  logic [31:0]              wdata_i,
  input  logic [ESR_W-1:0]         esr_set_i,
  output logic [31:0]              id_o,
  output logic [31:0]              tpr_o,
  output logic [31:0]              ldr_o,
  output logic [31:0]              dfr_o,
  output logic [31:0]              svr_o,
  output logic [31:0]              esr_o,
  output logic [31:0]              icnt_o,
  output logic [31:0]              div_o,
  output logic [NUM_LVT-1:0][31:0] lvt_o,
  output logic                     eoi_o
);
  logic [7:0]       id_q, tpr_q, ldr_q;
  logic [3:0]       dfr_q;
  logic [31:0]      svr_q, icnt_q;
  logic [2:0]       div_q;
  logic [ESR_W-1:0] esr_q, esr_d;
  logic             armed_q, armed_d, eoi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q   <= '0;
      tpr_q  <= '0;
      ldr_q  <= '0;
      dfr_q  <= '1;
      svr_q  <= 32'h0000_00FF;
      icnt_q <= '0;
      div_q  <= '0;
      eoi_q  <= 1'b0;
    end else begin
      eoi_q <= wr_en_i && (sel_i == SEL_EOI);
      if (wr_en_i) begin
        case (sel_i)
          SEL_ID:   id_q   <= wdata_i[7:0];
          SEL_TPR:  tpr_q  <= wdata_i[7:0];
          SEL_LDR:  ldr_q  <= wdata_i[31:24];
          SEL_DFR:  dfr_q  <= wdata_i[31:28];
          SEL_SVR:  svr_q  <= wdata_i;
          SEL_ICNT: icnt_q <= wdata_i;
          SEL_DIV:  div_q  <= {wdata_i[3], wdata_i[1:0]};
          default: ;
        endcase
      end
    end
  end

  // error status: first write arms, second clears, read disarms
  always_comb begin
    esr_d   = esr_q;
    armed_d = armed_q;
    if (rd_en_i && sel_i == SEL_ESR) armed_d = 1'b0;
    if (wr_en_i && sel_i == SEL_ESR) begin
      if (armed_q) begin
        esr_d   = '0;
        armed_d = 1'b0;
      end else begin
        armed_d = 1'b1;
      end
    end
    esr_d = esr_d | esr_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      esr_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      esr_q   <= esr_d;
      armed_q <= armed_d;
    end
  end

  for (genvar i = 0; i < NUM_LVT; i++) begin : g_lvt
    logic [31:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q <= LVT_RST;
      else if (wr_en_i && sel_i == SEL_LVT && lvt_idx_i == LVT_W'(i))
        ent_q <= (wdata_i & ~LVT_RO_MASK) | (ent_q & LVT_RO_MASK);
    end
    assign lvt_o[i] = ent_q;

    a_r5_ro_bits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $stable(ent_q[12]) && $stable(ent_q[14]));
  end

  assign id_o   = {24'b0, id_q};
  assign tpr_o  = {24'b0, tpr_q};
  assign ldr_o  = {ldr_q, 24'b0};
  assign dfr_o  = {dfr_q, 28'hFFF_FFFF};
  assign svr_o  = svr_q;
  assign esr_o  = 32'(esr_q);
  assign icnt_o = icnt_q;
  assign div_o  = {28'b0, div_q[2], 1'b0, div_q[1:0]};
  assign eoi_o  = eoi_q;

  a_r7_eoi_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_q |-> $past(wr_en_i && sel_i == SEL_EOI));

  a_r8_swen_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(svr_q[8]) |-> $past(wr_en_i && sel_i == SEL_SVR));
endmodule

// File: rtl/intc_rdmux.sv
module intc_rdmux
  import intc_pkg::*;
#(
  parameter int NUM_VEC   = 256,
  parameter int ARR_WORDS = 16,
  parameter int NUM_LVT   = 6,
  parameter logic [31:0] VERSION = 32'h0005_0014,
  localparam int IDX_W    = $clog2(ARR_WORDS),
  localparam int LVT_W    = $clog2(NUM_LVT),
  localparam int VPW      = NUM_VEC / ARR_WORDS
) (
  input  reg_sel_e                 sel_i,
  input  logic [IDX_W-1:0]         arr_idx_i,
  input  logic [LVT_W-1:0]         lvt_idx_i,
  input  logic [31:0]              id_i,
  input  logic [31:0]              tpr_i,
  input  logic [31:0]              ldr_i,
  input  logic [31:0]              dfr_i,
  input  logic [31:0]              svr_i,
  input  logic [31:0]              esr_i,
  input  logic [31:0]              icnt_i,
  input  logic [31:0]              div_i,
  input  logic [31:0]              ccnt_i,
  input  logic [NUM_LVT-1:0][31:0] lvt_i,
  input  logic [NUM_VEC-1:0]       irr_i,
  input  logic [NUM_VEC-1:0]       isr_i,
  input  logic [NUM_VEC-1:0]       tmr_i,
  output logic [31:0]              data_o,
  output logic                     hit_o
);
  always_comb begin
    hit_o = (sel_i != SEL_NONE);
    case (sel_i)
      SEL_ID:   data_o = id_i;
      SEL_VER:  data_o = VERSION;
      SEL_TPR:  data_o = tpr_i;
      SEL_LDR:  data_o = ldr_i;
      SEL_DFR:  data_o = dfr_i;
      SEL_SVR:  data_o = svr_i;
      SEL_ESR:  data_o = esr_i;
      SEL_ICNT: data_o = icnt_i;
      SEL_CCNT: data_o = ccnt_i;
      SEL_DIV:  data_o = div_i;
      SEL_LVT:  data_o = lvt_i[lvt_idx_i];
      SEL_ISR:  data_o = 32'(isr_i[arr_idx_i*VPW +: VPW]);
      SEL_TMR:  data_o = 32'(tmr_i[arr_idx_i*VPW +: VPW]);
      SEL_IRR:  data_o = 32'(irr_i[arr_idx_i*VPW +: VPW]);
      default:  data_o = '0;
    endcase
  end
endmodule

// File: rtl/intc_regbank.sv
module intc_regbank
  import intc_pkg::*;
#(
  parameter int NUM_VEC   = 256,
  parameter int ARR_WORDS = 16,
  parameter int NUM_LVT   = 6,
  parameter int ESR_W     = 8,
  parameter logic [31:0] VERSION = 32'h0005_0014,
  localparam int ADDR_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [NUM_VEC-1:0] irr_i,
  input  logic [NUM_VEC-1:0] isr_i,
  input  logic [NUM_VEC-1:0] tmr_i,
  input  logic [31:0]       cur_count_i,
  input  logic [ESR_W-1:0]  esr_set_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  output logic              rd_err_o,
  output logic [7:0]        tpr_o,
  output logic              sw_en_o,
  output logic              eoi_o
);
  localparam int IDX_W = $clog2(ARR_WORDS);
  localparam int LVT_W = $clog2(NUM_LVT);

  reg_sel_e                 sel;
  logic [IDX_W-1:0]         arr_idx;
  logic [LVT_W-1:0]         lvt_idx;
  logic [31:0]              id_w, tpr_w, ldr_w, dfr_w, svr_w, esr_w, icnt_w, div_w;
  logic [NUM_LVT-1:0][31:0] lvt_w;
  logic [31:0]              rd_data;
  logic                     rd_hit, wr_en, rd_en;

  assign wr_en = req_i && we_i;
  assign rd_en = req_i && !we_i;

  intc_decode #(.ADDR_W(ADDR_W), .ARR_WORDS(ARR_WORDS), .NUM_LVT(NUM_LVT)) u_dec (
    .addr_i(addr_i), .sel_o(sel), .arr_idx_o(arr_idx), .lvt_idx_o(lvt_idx)
  );

  intc_wregs #(.NUM_LVT(NUM_LVT), .ESR_W(ESR_W)) u_wregs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .sel_i(sel), .lvt_idx_i(lvt_idx), .wdata_i(wdata_i), .esr_set_i(esr_set_i),
    .id_o(id_w), .tpr_o(tpr_w), .ldr_o(ldr_w), .dfr_o(dfr_w), .svr_o(svr_w),
    .esr_o(esr_w), .icnt_o(icnt_w), .div_o(div_w), .lvt_o(lvt_w), .eoi_o(eoi_o)
  );

  intc_rdmux #(.NUM_VEC(NUM_VEC), .ARR_WORDS(ARR_WORDS), .NUM_LVT(NUM_LVT),
               .VERSION(VERSION)) u_rdmux (
    .sel_i(sel), .arr_idx_i(arr_idx), .lvt_idx_i(lvt_idx),
    .id_i(id_w), .tpr_i(tpr_w), .ldr_i(ldr_w), .dfr_i(dfr_w), .svr_i(svr_w),
    .esr_i(esr_w), .icnt_i(icnt_w), .div_i(div_w), .ccnt_i(cur_count_i),
    .lvt_i(lvt_w), .irr_i(irr_i), .isr_i(isr_i), .tmr_i(tmr_i),
    .data_o(rd_data), .hit_o(rd_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
      rd_err_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en;
      rd_err_o <= rd_en && !rd_hit;
      if (rd_en) rdata_o <= rd_data;
    end
  end

  assign tpr_o   = tpr_w[7:0];
  assign sw_en_o = svr_w[8];

  a_r2_tpr_moves_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tpr_o) |-> $past(wr_en));

  a_r11_rvalid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(rd_en));

  a_r12_err_with_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> rvalid_o && rdata_o == '0);
endmodule

// File: tb/intc_regbank_tb.sv
module intc_regbank_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [255:0] irr = '0, isr = '0, tmr = '0;
  logic [31:0] ccnt = 32'h0000_1357;
  logic [7:0]  esr_set = '0;
  logic [31:0] rdata;
  logic        rvalid, rd_err, sw_en, eoi;
  logic [7:0]  tpr;

  int checks = 0, fails = 0;
  logic [31:0] rv;
  logic        re, rvl;
  localparam logic [31:0] VER = 32'h0005_0014;

  always #10 clk = ~clk;

  intc_regbank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .irr_i(irr), .isr_i(isr), .tmr_i(tmr),
    .cur_count_i(ccnt), .esr_set_i(esr_set), .rdata_o(rdata),
    .rvalid_o(rvalid), .rd_err_o(rd_err), .tpr_o(tpr), .sw_en_o(sw_en),
    .eoi_o(eoi)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [11:0] a);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
    rv = rdata; re = rd_err; rvl = rvalid;
  endtask

  task automatic t_reset();
    chk("R1 tpr_o", 32'(tpr), 0);
    chk("R1 sw_en_o", 32'(sw_en), 0);
    chk("R1 eoi_o", 32'(eoi), 0);
    chk("R1 rvalid_o", 32'(rvalid), 0);
    rd(12'h020); chk("R1 id", rv, 0);
    rd(12'h0E0); chk("R1 dfr", rv, 32'hFFFF_FFFF);
    rd(12'h0F0); chk("R1 svr", rv, 32'h0000_00FF);
    for (int k = 0; k < 6; k++) begin
      rd(12'h320 + 12'(k * 16)); chk("R1 lvt", rv, 32'h0001_0000);
    end
    rd(12'h3E0); chk("R1 div", rv, 0);
    rd(12'h280); chk("R1 esr", rv, 0);
  endtask

  task automatic t_id_tpr();
    wr(12'h020, 32'hDEAD_BEEF); rd(12'h020); chk("R2 id mask", rv, 32'hEF);
    wr(12'h080, 32'h1234_5678);
    chk("R2 tpr_o", 32'(tpr), 32'h78);
    rd(12'h080); chk("R2 tpr read", rv, 32'h78);
  endtask

  task automatic t_dest();
    wr(12'h0D0, 32'hABCD_EF12); rd(12'h0D0); chk("R3 ldr", rv, 32'hAB00_0000);
    wr(12'h0E0, 32'h3000_0000); rd(12'h0E0); chk("R3 dfr", rv, 32'h3FFF_FFFF);
  endtask

  task automatic t_readonly();
    wr(12'h030, 32'h0); rd(12'h030); chk("R4 version", rv, VER);
    rd(12'h390); chk("R4 ccnt", rv, 32'h1357);
    wr(12'h390, 32'hFFFF_0000); ccnt = 32'h0000_2468;
    rd(12'h390); chk("R4 ccnt write ignored", rv, 32'h2468);
  endtask

  task automatic t_lvt();
    wr(12'h340, 32'hFFFF_FFFF); rd(12'h340); chk("R5 lvt ro bits", rv, 32'hFFFF_AFFF);
    rd(12'h320); chk("R5 other entry", rv, 32'h0001_0000);
    wr(12'h370, 32'h0000_5000); rd(12'h370); chk("R5 ro set ignored", rv, 0);
  endtask

  task automatic t_esr();
    @(negedge clk); esr_set = 8'h44; @(negedge clk); esr_set = 0;
    wr(12'h280, 0); wr(12'h280, 0); rd(12'h280); chk("R6 two writes clear", rv, 0);
    @(negedge clk); esr_set = 8'h21; @(negedge clk); esr_set = 0;
    wr(12'h280, 0); rd(12'h280); chk("R6 first write arms only", rv, 32'h21);
    wr(12'h280, 0); rd(12'h280); chk("R6 read disarms", rv, 32'h21);
    wr(12'h280, 0); wr(12'h280, 0); rd(12'h280); chk("R6 clear", rv, 0);
  endtask

  task automatic t_eoi();
    wr(12'h0B0, 32'h0); chk("R7 eoi pulse", 32'(eoi), 1);
    @(negedge clk); chk("R7 eoi one cycle", 32'(eoi), 0);
    rd(12'h0B0); chk("R7 eoi reads 0", rv, 0);
  endtask

  task automatic t_svr();
    wr(12'h0F0, 32'h0000_01FF); chk("R8 sw_en set", 32'(sw_en), 1);
    rd(12'h0F0); chk("R8 svr read", rv, 32'h1FF);
    wr(12'h0F0, 32'h0000_00FF); chk("R8 sw_en clear", 32'(sw_en), 0);
  endtask

  task automatic t_div_icnt();
    wr(12'h3E0, 32'hFFFF_FFFF); rd(12'h3E0); chk("R9 div mask", rv, 32'hB);
    wr(12'h380, 32'h89AB_CDEF); rd(12'h380); chk("R9 icnt", rv, 32'h89AB_CDEF);
  endtask

  task automatic t_arrays();
    irr[16*15 +: 16] = 16'hA5C3;
    isr[0 +: 16]     = 16'h8001;
    tmr[16*7 +: 16]  = 16'h1234;
    irr[0 +: 16]     = 16'h00F0;
    rd(12'h278); chk("R10 irr word15", rv, 32'hA5C3);
    rd(12'h100); chk("R10 isr word0", rv, 32'h8001);
    rd(12'h1B8); chk("R10 tmr word7", rv, 32'h1234);
    wr(12'h200, 32'hFFFF_FFFF); rd(12'h200); chk("R10 irr write ignored", rv, 32'hF0);
  endtask

  task automatic t_latency();
    rd(12'h024); chk("R11 alias id", rv, 32'hEF); chk("R11 rvalid", 32'(rvl), 1);
    @(negedge clk); chk("R11 rvalid one cycle", 32'(rvalid), 0);
  endtask

  task automatic t_reserved();
    rd(12'h090); chk("R12 rsvd data", rv, 0); chk("R12 rsvd err", 32'(re), 1);
    rd(12'h080); chk("R12 no err on valid", 32'(re), 0);
    wr(12'h090, 32'h55); wr(12'h028, 32'h66);
    rd(12'h080); chk("R12 tpr unchanged", rv, 32'h78);
    rd(12'h020); chk("R12 id unchanged", rv, 32'hEF);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_id_tpr();
    t_dest();
    t_readonly();
    t_lvt();
    t_esr();
    t_eoi();
    t_svr();
    t_div_icnt();
    t_arrays();
    t_latency();
    t_reserved();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule